// File: doc/BRIEF.md
# Distributed Queuing Rate Calculator

Each port of an eight-port switch carries one of these engines. It paces the traffic that each virtual output queue sends into the fabric. The goal is to keep the fabric free of congestion while still keeping every output queue fed. On each period tick the engine does two things. First, it captures its own backlog state and streams it out as a twelve-word summary record, which the fabric broadcasts to every port. Second, it starts a rate computation over the summaries that every port has delivered so far, including its own.

For output j, the engine takes two shares of the backlog held by this port. The first is its share of the input-side backlog to output j. The second is its share of the total backlog for output j, which also counts the output queue itself. The second share is normalised across all eight outputs of this port. The pacing rate is the smaller of the two shares, multiplied by the link rate and by the fabric speedup. All eight rates are published together, with a one-cycle strobe.

Top module: `dq_rate_calc`

## Requirements
- R1: On the cycle after `tick` is sampled high, `rec_out_valid` rises for 12 consecutive cycles, one word per cycle. The words, in order, are:
  - the port number `my_port` in the low 3 bits, upper bits zero;
  - `link_rate`;
  - `oq_len`;
  - zero;
  - then lanes 0 to 7 of `voq_len`.
  All local values are captured at the tick.
- R2: A received record is 12 consecutive valid words on `rec_in_word`. The low 3 bits of word 0 select the source slot. Word 2 is stored as that source's output-queue length. Words 4 to 11 are stored as its backlogs to outputs 0 to 7. Word 3 is ignored.
- R3: A computation uses only records completed before the tick cycle. A record that arrives after a tick takes effect at the following tick.
- R4: A source that sends no record in a period keeps its last stored values.
- R5: Shares are unsigned with 16 fractional bits and truncated, where v is this port's backlog to j, C the sum of all sources' backlogs to j, and Q source j's stored output-queue length:
  - hi = (v·2^16)/C;
  - lo = (v·2^16)/(C+Q);
  - wt = (lo·2^16)/Σ lo.
  Any share whose denominator is zero is 0.
- R6: rate_j = floor(link_rate · speedup · min(wt_j, hi_j) / 2^16). Lane j occupies `rate_out[21j +: 21]`.
- R7: All eight lanes of `rate_out` change on one edge, the same edge that raises `rate_valid`. `rate_valid` lasts exactly one cycle. At all other times `rate_out` holds.
- R8: Reset clears the rates, both strobes and all stored summaries to zero.
- R9: Word 1 of a received record (the overall rate) has no effect on any rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_port | input | 3 | Number of this port |
| tick | input | 1 | Period pulse: emit record and start computation |
| link_rate | input | 16 | External link rate L |
| speedup | input | 4 | Fabric speedup S (integer) |
| oq_len | input | 16 | Local output-queue byte count |
| voq_len | input | 128 | Local VOQ byte counts, lane j at [16j +: 16] |
| rec_in_valid | input | 1 | Incoming record word valid |
| rec_in_word | input | 16 | Incoming record word |
| rec_out_valid | output | 1 | Outgoing record word valid |
| rec_out_word | output | 16 | Outgoing record word |
| rate_valid | output | 1 | One-cycle strobe for a new rate vector |
| rate_out | output | 168 | Eight pacing rates, 21 bits each |

## Verification
The computation is exercised with several backlog patterns:
- **Uniform backlogs.** Both shares are equal, so this checks the plain scaling by link rate and speedup.
- **Skewed backlogs with large output queues.** The normalised total-backlog share wins over the input-side share, which confirms that the minimum is taken per output.
- **All-zero state and a column that is zero except for its output queue.** These drive the zero-denominator rule.
- **Records withheld, sent late (during a computation), or differing only in the overall-rate word.** These separate the snapshot semantics from the reuse of stale values and from a field that must be ignored.
- **A different port number.** This confirms that the engine selects its own row.

// File: rtl/dq_rate_calc.sv
module dq_rate_calc #(
  parameter int NP    = 8,
  parameter int W     = 16,
  parameter int SPD_W = 4,
  parameter int FRAC  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [$clog2(NP)-1:0] my_port,
  input  logic                 tick,
  input  logic [W-1:0]         link_rate,
  input  logic [SPD_W-1:0]     speedup,
  input  logic [W-1:0]         oq_len,
  input  logic [NP*W-1:0]      voq_len,
  input  logic                 rec_in_valid,
  input  logic [W-1:0]         rec_in_word,
  output logic                 rec_out_valid,
  output logic [W-1:0]         rec_out_word,
  output logic                 rate_valid,
  output logic [NP*(W+SPD_W+1)-1:0] rate_out
);
  localparam int PW     = $clog2(NP);
  localparam int RW     = NP + 4;
  localparam int CW     = $clog2(RW);
  localparam int SHW    = FRAC + 1;
  localparam int CSW    = W + PW;
  localparam int TW     = CSW + 1;
  localparam int LSW    = SHW + PW;
  localparam int DENW   = (TW > LSW) ? TW : LSW;
  localparam int NUMW   = SHW + FRAC;
  localparam int PRW    = W + SPD_W + SHW;
  localparam int RATE_W = W + SPD_W + 1;

  logic [W-1:0] p_oq [NP];
  logic [W-1:0] p_voq[NP][NP];
  logic [W-1:0] s_oq [NP];
  logic [W-1:0] s_voq[NP][NP];

  logic [CW-1:0] in_cnt;
  logic [PW-1:0] in_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt <= '0;
      in_src <= '0;
      for (int a = 0; a < NP; a++) begin
        p_oq[a] <= '0;
        s_oq[a] <= '0;
        for (int b = 0; b < NP; b++) begin
          p_voq[a][b] <= '0;
          s_voq[a][b] <= '0;
        end
      end
    end else begin
      if (rec_in_valid) begin
        in_cnt <= (in_cnt == CW'(RW-1)) ? '0 : in_cnt + 1'b1;
        if (in_cnt == '0) in_src <= rec_in_word[PW-1:0];
        if (in_cnt == CW'(2)) p_oq[in_src] <= rec_in_word;
        if (in_cnt >= CW'(4)) p_voq[in_src][PW'(in_cnt - CW'(4))] <= rec_in_word;
      end
      if (tick) begin
        s_oq  <= p_oq;
        s_voq <= p_voq;
      end
    end
  end

  logic [CW-1:0]   out_cnt;
  logic            out_busy;
  logic [PW-1:0]   l_port;
  logic [W-1:0]    l_rate, l_oq;
  logic [NP*W-1:0] l_voq;
  logic [PW-1:0]   oidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_busy <= 1'b0;
      out_cnt  <= '0;
      l_port   <= '0;
      l_rate   <= '0;
      l_oq     <= '0;
      l_voq    <= '0;
    end else if (tick) begin
      out_busy <= 1'b1;
      out_cnt  <= '0;
      l_port   <= my_port;
      l_rate   <= link_rate;
      l_oq     <= oq_len;
      l_voq    <= voq_len;
    end else if (out_busy) begin
      if (out_cnt == CW'(RW-1)) out_busy <= 1'b0;
      else out_cnt <= out_cnt + 1'b1;
    end
  end

  assign oidx = PW'(out_cnt - CW'(4));
  assign rec_out_valid = out_busy;

  always_comb begin
    case (out_cnt)
      CW'(0):  rec_out_word = W'(l_port);
      CW'(1):  rec_out_word = l_rate;
      CW'(2):  rec_out_word = l_oq;
      CW'(3):  rec_out_word = '0;
      default: rec_out_word = l_voq[oidx*W +: W];
    endcase
  end

  logic            busy_c;
  logic [1:0]      phase;
  logic [PW-1:0]   j;
  logic [SHW-1:0]  hi[NP], lo[NP], wt[NP];
  logic [CSW-1:0]  colsum;
  logic [TW-1:0]   tot;
  logic [LSW-1:0]  losum;
  logic [NUMW-1:0] num;
  logic [DENW-1:0] den;
  logic [NUMW-1:0] quo;
  logic [SHW-1:0]  q;
  logic [NP*RATE_W-1:0] rate_nx;

  always_comb begin
    colsum = '0;
    losum  = '0;
    for (int k = 0; k < NP; k++) begin
      colsum = colsum + CSW'(s_voq[k][j]);
      losum  = losum + LSW'(lo[k]);
    end
    tot = TW'(colsum) + TW'(s_oq[j]);
    case (phase)
      2'd0:    begin num = NUMW'(s_voq[l_port][j]) << FRAC; den = DENW'(colsum); end
      2'd1:    begin num = NUMW'(s_voq[l_port][j]) << FRAC; den = DENW'(tot);    end
      default: begin num = NUMW'(lo[j]) << FRAC;             den = DENW'(losum);  end
    endcase
    quo = (den == '0) ? '0 : num / NUMW'(den);
    q   = SHW'(quo);
  end

  for (genvar g = 0; g < NP; g++) begin : g_rate
    logic [SHW-1:0] mn;
    logic [PRW-1:0] prod;
    assign mn   = (wt[g] < hi[g]) ? wt[g] : hi[g];
    assign prod = PRW'(link_rate) * PRW'(speedup) * PRW'(mn);
    assign rate_nx[g*RATE_W +: RATE_W] = RATE_W'(prod >> FRAC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_c     <= 1'b0;
      phase      <= '0;
      j          <= '0;
      rate_valid <= 1'b0;
      rate_out   <= '0;
      for (int a = 0; a < NP; a++) begin
        hi[a] <= '0;
        lo[a] <= '0;
        wt[a] <= '0;
      end
    end else begin
      rate_valid <= 1'b0;
      if (tick) begin
        busy_c <= 1'b1;
        phase  <= '0;
        j      <= '0;
      end else if (busy_c) begin
        case (phase)
          2'd0: hi[j] <= q;
          2'd1: lo[j] <= q;
          2'd2: wt[j] <= q;
          default: ;
        endcase
        if (phase == 2'd3) begin
          rate_out   <= rate_nx;
          rate_valid <= 1'b1;
          busy_c     <= 1'b0;
        end else if (j == PW'(NP-1)) begin
          j     <= '0;
          phase <= phase + 1'b1;
        end else begin
          j <= j + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dq_rate_calc_chk.sv
module dq_rate_calc_chk #(
  parameter int NP    = 8,
  parameter int W     = 16,
  parameter int SPD_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [$clog2(NP)-1:0] my_port,
  input logic [W-1:0]          link_rate,
  input logic [SPD_W-1:0]      speedup,
  input logic                  rec_out_valid,
  input logic [W-1:0]          rec_out_word,
  input logic                  rate_valid,
  input logic [NP*(W+SPD_W+1)-1:0] rate_out
);
  localparam int RATE_W = W + SPD_W + 1;

  a_r1_first_word_port: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_out_valid) |-> rec_out_word == W'($past(my_port)));

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rate_valid |=> !rate_valid);

  a_r7_rates_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_valid |-> $stable(rate_out));

  for (genvar g = 0; g < NP; g++) begin : g_bound
    a_r6_rate_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_valid && $stable(link_rate) && $stable(speedup)) |->
        RATE_W'(rate_out[g*RATE_W +: RATE_W]) <= RATE_W'(link_rate) * RATE_W'(speedup));
  end
endmodule

bind dq_rate_calc dq_rate_calc_chk #(.NP(NP), .W(W), .SPD_W(SPD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .my_port(my_port), .link_rate(link_rate),
  .speedup(speedup), .rec_out_valid(rec_out_valid), .rec_out_word(rec_out_word),
  .rate_valid(rate_valid), .rate_out(rate_out));

// File: tb/dq_rate_calc_tb_top.sv
module dq_rate_calc_tb_top;
  localparam int NP = 8, W = 16, SPD_W = 4, RATE_W = W + SPD_W + 1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rec_in_valid = 1'b0;
  logic [2:0] my_port = '0;
  logic [W-1:0] link_rate = '0, oq_len = '0, rec_in_word = '0, rec_out_word;
  logic [SPD_W-1:0] speedup = '0;
  logic [NP*W-1:0] voq_len = '0;
  logic rec_out_valid, rate_valid;
  logic [NP*RATE_W-1:0] rate_out;

  always #5 clk = ~clk;

  dq_rate_calc dut_i (.clk(clk), .rst_n(rst_n), .my_port(my_port), .tick(tick),
    .link_rate(link_rate), .speedup(speedup), .oq_len(oq_len), .voq_len(voq_len),
    .rec_in_valid(rec_in_valid), .rec_in_word(rec_in_word), .rec_out_valid(rec_out_valid),
    .rec_out_word(rec_out_word), .rate_valid(rate_valid), .rate_out(rate_out));

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] exp_w[$];
  string        exp_wt[$];
  logic [NP*RATE_W-1:0] exp_r[$];
  string        exp_rt[$];

  int nx_oq[NP], nx_voq[NP][NP];
  int m_oq[NP],  m_voq[NP][NP];

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rec_out_valid) begin
      if (exp_w.size() == 0) check(0, "R1", "unexpected record word", rec_out_word, 0);
      else begin
        logic [W-1:0] e; string t;
        e = exp_w.pop_front(); t = exp_wt.pop_front();
        check(rec_out_word == e, t, "record word", rec_out_word, e);
      end
    end
    if (rate_valid) begin
      if (exp_r.size() == 0) check(0, "R7", "unexpected rate strobe", 0, 0);
      else begin
        logic [NP*RATE_W-1:0] e; string t;
        e = exp_r.pop_front(); t = exp_rt.pop_front();
        n_chk++;
        if (rate_out != e) begin
          n_fail++;
          $display("FAIL %s rates actual=%h expected=%h", t, rate_out, e);
        end
      end
    end
  end

  function automatic logic [NP*RATE_W-1:0] model(int p, longint L, longint S);
    longint hi[NP], lo[NP], ls, col, tot, own, wt, mn;
    logic [NP*RATE_W-1:0] r;
    ls = 0;
    for (int j = 0; j < NP; j++) begin
      col = 0;
      for (int k = 0; k < NP; k++) col += m_voq[k][j];
      tot = col + m_oq[j];
      own = m_voq[p][j];
      hi[j] = (col == 0) ? 0 : (own << 16) / col;
      lo[j] = (tot == 0) ? 0 : (own << 16) / tot;
      ls += lo[j];
    end
    for (int j = 0; j < NP; j++) begin
      wt = (ls == 0) ? 0 : (lo[j] << 16) / ls;
      mn = (wt < hi[j]) ? wt : hi[j];
      r[j*RATE_W +: RATE_W] = RATE_W'((L * S * mn) >> 16);
    end
    return r;
  endfunction

  task automatic send_rec(int src, int rword);
    int wd;
    for (int i = 0; i < NP + 4; i++) begin
      case (i)
        0: wd = src;
        1: wd = rword;
        2: wd = nx_oq[src];
        3: wd = rword ^ 16'h5a5a;
        default: wd = nx_voq[src][i-4];
      endcase
      @(negedge clk);
      rec_in_valid = 1'b1;
      rec_in_word  = W'(wd);
    end
    @(negedge clk);
    rec_in_valid = 1'b0;
    m_oq[src] = nx_oq[src];
    for (int j = 0; j < NP; j++) m_voq[src][j] = nx_voq[src][j];
  endtask

  task automatic set_local();
    oq_len = W'(nx_oq[my_port]);
    for (int j = 0; j < NP; j++) voq_len[j*W +: W] = W'(nx_voq[my_port][j]);
  endtask

  task automatic do_tick(string rtag);
    exp_w.push_back(W'(my_port)); exp_wt.push_back("R1");
    exp_w.push_back(link_rate);   exp_wt.push_back("R1");
    exp_w.push_back(oq_len);      exp_wt.push_back("R1");
    exp_w.push_back('0);          exp_wt.push_back("R1");
    for (int j = 0; j < NP; j++) begin
      exp_w.push_back(voq_len[j*W +: W]); exp_wt.push_back("R1");
    end
    exp_r.push_back(model(my_port, link_rate, speedup)); exp_rt.push_back(rtag);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wait_done();
    logic [NP*RATE_W-1:0] prev;
    int g = 0;
    while (!rate_valid && g < 200) begin @(negedge clk); g++; end
    prev = rate_out;
    @(negedge clk);
    check(!rate_valid && rate_out == prev, "R7", "strobe width / hold", rate_valid, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic send_all(int rbase);
    for (int s = 0; s < NP; s++) send_rec(s, rbase + s);
  endtask

  initial begin
    #(50000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < NP; a++) begin
      m_oq[a] = 0;
      for (int b = 0; b < NP; b++) m_voq[a][b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rate_out == '0, "R8", "rates after reset", 0, 0);
    check(!rate_valid, "R8", "rate strobe after reset", rate_valid, 0);
    check(!rec_out_valid, "R8", "record valid after reset", rec_out_valid, 0);

    link_rate = 16'd1000; speedup = 4'd2; my_port = 3'd0;
    do_tick("R8"); wait_done();

    for (int s = 0; s < NP; s++) begin
      nx_oq[s] = 0;
      for (int d = 0; d < NP; d++) nx_voq[s][d] = 1000;
    end
    set_local(); send_all(0); do_tick("R6"); wait_done();

    for (int s = 0; s < NP; s++) begin
      nx_oq[s] = 4000 + s * 3001;
      for (int d = 0; d < NP; d++) nx_voq[s][d] = (s * 37 + d * 101 + 7) % 5000 + ((s == 0) ? 9000 : 0);
    end
    link_rate = 16'd50000; speedup = 4'd3;
    set_local(); send_all(100); do_tick("R5"); wait_done();

    my_port = 3'd5; link_rate = 16'd777; speedup = 4'd15;
    set_local(); do_tick("R6"); wait_done();

    nx_voq[3][2] = 60000; nx_oq[6] = 12;
    send_rec(3, 55); do_tick("R4"); wait_done();

    for (int s = 0; s < NP; s++) nx_voq[s][4] = 0;
    nx_oq[4] = 30000;
    set_local(); send_all(200); do_tick("R5"); wait_done();

    nx_voq[5][1] = 1; set_local();
    do_tick("R3");
    send_rec(5, 9);
    wait_done();
    do_tick("R3"); wait_done();

    send_all(16'hbeef); do_tick("R9"); wait_done();

    my_port = 3'd7; speedup = 4'd1; link_rate = 16'hffff;
    nx_voq[7][0] = 0; send_rec(7, 1); set_local();
    do_tick("R2"); wait_done();

    repeat (20) @(negedge clk);
    check(exp_w.size() == 0 && exp_r.size() == 0, "R1", "pending expectations",
          exp_w.size() + exp_r.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule